// File: doc/BRIEF.md
# GF(2^113) Multiplicative Inverter

This block returns the multiplicative inverse of an element of the binary field GF(2^113). The field polynomial is the trinomial x^113 + x^9 + 1. The inverse is found by raising the operand to the power 2^113 - 2, as Fermat's little theorem allows. No Euclidean loop is used. A controller walks a fixed addition chain in the exponent. That chain needs 112 squarings and 8 multiplications, so every operand takes the same number of cycles. This makes the block easy to slot into a pipeline whose schedule is fixed in advance.

One combinational squarer and one digit-serial multiplier are shared across the whole chain. The sequencer sets a running value to the operand. Each doubling step takes the exponent form a^(2^k - 1) to a^(2^(2k) - 1): the running value is squared k times and then multiplied by the copy saved at the start of the step. Each increment step squares once and multiplies by the operand. One last squaring gives the result. Element bit i is the coefficient of x^i.

A caller presents an operand with a one-cycle strobe while the busy flag is low. It then waits for the result strobe.

Top module: `gf_inverse`

## Requirements
- R1: For any nonzero operand a, the product of a and the result, reduced modulo x^113 + x^9 + 1, equals 1. Bit i of each element is the coefficient of x^i.
- R2: An all-zero operand gives an all-zero result, and no separate flag is raised.
- R3: The operand 1 gives 1. The operand x (only bit 1 set) gives x^112 + x^8 (only bits 112 and 8 set).
- R4: `out_valid` rises exactly LAT clock edges after the edge that accepts the operand, whatever its value. With the default digit width of 8, LAT is 257.
- R5: `busy` is high from the edge that accepts an operand until the edge that raises `out_valid`. It falls on that same edge.
- R6: While `busy` is high, `in_valid` and `in_data` are ignored. The running computation keeps its operand and its timing, and no extra result follows.
- R7: `out_valid` is high for exactly one cycle per accepted operand. `out_data` holds the result from that cycle on.
- R8: After reset, `busy` and `out_valid` are low and `out_data` is zero.
- R9: A new operand may be presented in the same cycle that `out_valid` is high. It is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe, taken only while busy is low |
| in_data | input | 113 | Field element to invert |
| busy | output | 1 | An inversion is in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 113 | Inverse of the accepted operand |

## Verification
The result is due exactly 257 edges after the accepting edge. That count comes from eight chain steps, each costing one planning edge, its squarings, and the 15 multiplier digit cycles plus a load and a capture edge, followed by two closing edges. The bench drives stimulus on falling edges. It counts rising edges from the accepting edge until it sees `out_valid` at a falling edge, and compares that count with 257. It also confirms that the strobe has dropped one edge later, and that operands offered mid-run change neither the value nor the timing. For back-to-back use, the second operand is driven in the very cycle the first strobe is seen.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

  localparam int FIELD_M = 113;
  localparam int TRI_MID = 9;
  localparam int DIGIT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_SQR,
    ST_MUL,
    ST_FIN
  } inv_state_t;

  // index of the highest set bit of v
  function automatic int top_bit(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if (((v >> i) & 1) == 1) r = i;
    end
    return r;
  endfunction

  // clock edges from operand acceptance to the result strobe
  function automatic int inv_latency(input int m, input int d);
    int nd, e, k, cyc;
    nd  = (m + d - 1) / d;
    e   = m - 1;
    k   = 1;
    cyc = 0;
    for (int i = top_bit(m - 1) - 1; i >= 0; i--) begin
      cyc = cyc + 3 + k + nd;
      k   = 2 * k;
      if (((e >> i) & 1) == 1) begin
        cyc = cyc + 4 + nd;
        k   = k + 1;
      end
    end
    return cyc + 2;
  endfunction

endpackage

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int M = gfinv_pkg::FIELD_M,
  parameter int T = gfinv_pkg::TRI_MID
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);

  localparam int WW = 2 * M - 1;

  logic [WW-1:0] wide;

  always_comb begin
    wide = '0;
    for (int i = 0; i < M; i++) wide[2*i] = a[i];
    for (int i = WW - 1; i >= M; i--) begin
      if (wide[i]) begin
        wide[i-M+T] = wide[i-M+T] ^ 1'b1;
        wide[i-M]   = wide[i-M] ^ 1'b1;
        wide[i]     = 1'b0;
      end
    end
    y = wide[M-1:0];
  end

endmodule

// File: rtl/gf_mul_digit.sv
module gf_mul_digit #(
  parameter int M = gfinv_pkg::FIELD_M,
  parameter int T = gfinv_pkg::TRI_MID,
  parameter int D = gfinv_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         done,
  output logic [M-1:0] p
);

  localparam int ND   = (M + D - 1) / D;
  localparam int PADW = ND * D;
  localparam int CW   = $clog2(ND + 1);

  logic [M-1:0]    acc_q;
  logic [M-1:0]    a_q;
  logic [PADW-1:0] b_q;
  logic [CW-1:0]   cnt_q;
  logic [M-1:0]    acc_nx;

  function automatic logic [M-1:0] times_x(input logic [M-1:0] v);
    logic [M-1:0] r;
    r = {v[M-2:0], 1'b0};
    if (v[M-1]) begin
      r[0] = r[0] ^ 1'b1;
      r[T] = r[T] ^ 1'b1;
    end
    return r;
  endfunction

  // Horner step over one digit of b, most significant bit first
  always_comb begin
    acc_nx = acc_q;
    for (int j = 0; j < D; j++) begin
      acc_nx = times_x(acc_nx) ^ (b_q[PADW-1-j] ? a_q : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_q   <= a;
        b_q   <= PADW'(b);
        acc_q <= '0;
        cnt_q <= CW'(ND);
      end else if (cnt_q != '0) begin
        acc_q <= acc_nx;
        b_q   <= b_q << D;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign p = acc_q;

endmodule

// File: rtl/gf_inv_ctrl.sv
module gf_inv_ctrl #(
  parameter int M = gfinv_pkg::FIELD_M
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] in_data,
  output logic [M-1:0] sq_in,
  input  logic [M-1:0] sq_out,
  output logic         mul_start,
  output logic [M-1:0] mul_a,
  output logic [M-1:0] mul_b,
  input  logic         mul_done,
  input  logic [M-1:0] mul_p,
  output logic         busy,
  output logic         out_valid,
  output logic [M-1:0] out_data
);
  import gfinv_pkg::*;

  localparam int          TOPB = top_bit(M - 1);
  localparam logic [31:0] EXPV = 32'(M - 1);
  localparam int          KW   = $clog2(M) + 1;
  localparam int          IW   = $clog2(TOPB + 1) + 1;

  inv_state_t     state;
  logic [M-1:0]   acc;
  logic [M-1:0]   saved;
  logic [M-1:0]   op_q;
  logic [KW-1:0]  k_q;
  logic [KW-1:0]  sq_left;
  logic [IW-1:0]  idx;
  logic           plus_pend;
  logic           use_op;

  assign sq_in = acc;
  assign mul_a = acc;
  assign mul_b = use_op ? op_q : saved;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      acc       <= '0;
      saved     <= '0;
      op_q      <= '0;
      k_q       <= '0;
      sq_left   <= '0;
      idx       <= '0;
      plus_pend <= 1'b0;
      use_op    <= 1'b0;
      mul_start <= 1'b0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      mul_start <= 1'b0;
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            op_q      <= in_data;
            acc       <= in_data;
            k_q       <= KW'(1);
            idx       <= IW'(TOPB);
            plus_pend <= 1'b0;
            busy      <= 1'b1;
            state     <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (plus_pend) begin
            plus_pend <= 1'b0;
            sq_left   <= KW'(1);
            use_op    <= 1'b1;
            k_q       <= k_q + 1'b1;
            state     <= ST_SQR;
          end else if (idx != '0) begin
            saved     <= acc;
            sq_left   <= k_q;
            use_op    <= 1'b0;
            k_q       <= k_q << 1;
            plus_pend <= EXPV[idx-1'b1];
            idx       <= idx - 1'b1;
            state     <= ST_SQR;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_SQR: begin
          acc     <= sq_out;
          sq_left <= sq_left - 1'b1;
          if (sq_left == KW'(1)) begin
            mul_start <= 1'b1;
            state     <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (mul_done) begin
            acc   <= mul_p;
            state <= ST_NEXT;
          end
        end
        ST_FIN: begin
          out_data  <= sq_out;
          out_valid <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gf_inverse.sv
module gf_inverse #(
  parameter int M = gfinv_pkg::FIELD_M,
  parameter int T = gfinv_pkg::TRI_MID,
  parameter int D = gfinv_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] in_data,
  output logic         busy,
  output logic         out_valid,
  output logic [M-1:0] out_data
);

  logic [M-1:0] sq_in, sq_out, mul_a, mul_b, mul_p;
  logic         mul_start, mul_done;

  gf_sqr #(.M(M), .T(T)) u_sqr (
    .a (sq_in),
    .y (sq_out)
  );

  gf_mul_digit #(.M(M), .T(T), .D(D)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .start (mul_start),
    .a     (mul_a),
    .b     (mul_b),
    .done  (mul_done),
    .p     (mul_p)
  );

  gf_inv_ctrl #(.M(M)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .sq_in     (sq_in),
    .sq_out    (sq_out),
    .mul_start (mul_start),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .mul_done  (mul_done),
    .mul_p     (mul_p),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/gfinv_chk.sv
module gfinv_chk #(
  parameter int M   = gfinv_pkg::FIELD_M,
  parameter int LAT = 257
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] in_data,
  input logic         busy,
  input logic         out_valid,
  input logic [M-1:0] out_data
);

  logic [31:0]  cyc;
  logic [M-1:0] op_seen;
  logic         pend;
  logic         accept;

  assign accept = in_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= '0;
      op_seen <= '0;
      pend    <= 1'b0;
    end else begin
      if (accept) begin
        cyc     <= '0;
        op_seen <= in_data;
        pend    <= 1'b1;
      end else begin
        if (busy) cyc <= cyc + 1'b1;
        if (out_valid) pend <= 1'b0;
      end
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cyc == 32'(LAT)));

  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  assert_idle_at_result_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pend && (op_seen == '0)) |-> (out_data == '0));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pend);

endmodule

bind gf_inverse gfinv_chk #(
  .M   (M),
  .LAT (gfinv_pkg::inv_latency(M, D))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/gf_inverse_tb.sv
module gf_inverse_tb;

  localparam int M       = 113;
  localparam int EXP_LAT = 257;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [M-1:0] in_data = '0;
  logic         busy, out_valid;
  logic [M-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gf_inverse u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // schoolbook product then reduction by x^113 = x^9 + 1
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-2:0] full;
    full = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) full = full ^ ((2*M-1)'(a) << i);
    for (int i = 2*M-2; i >= M; i--)
      if (full[i]) begin
        full[i]       = 1'b0;
        full[i-M]     = full[i-M] ^ 1'b1;
        full[i-M+9]   = full[i-M+9] ^ 1'b1;
      end
    return full[M-1:0];
  endfunction

  function automatic logic [M-1:0] rand_elem();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    return r[M-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_result(output logic [M-1:0] r, output int lat);
    lat = 0;
    while (!out_valid && lat < 400) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    r = out_data;
  endtask

  task automatic run_op(input logic [M-1:0] a, output logic [M-1:0] r, output int lat);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_result(r, lat);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid, "R8 flags after reset", M'({busy, out_valid}), '0);
    check(out_data == '0, "R8 result after reset", out_data, '0);
  endtask

  task automatic t_known();
    logic [M-1:0] r, ex;
    int lat;
    run_op(M'(1), r, lat);
    check(r == M'(1), "R3 inverse of one", r, M'(1));
    @(negedge clk);
    check(!out_valid, "R7 strobe one cycle", M'(out_valid), '0);
    check(out_data == M'(1), "R7 result held", out_data, M'(1));
    ex = '0;
    ex[112] = 1'b1;
    ex[8]   = 1'b1;
    run_op(M'(2), r, lat);
    check(r == ex, "R3 inverse of x", r, ex);
    check(lat == EXP_LAT, "R4 latency for x", M'(lat), M'(EXP_LAT));
  endtask

  task automatic t_zero();
    logic [M-1:0] r;
    int lat;
    run_op('0, r, lat);
    check(r == '0, "R2 zero maps to zero", r, '0);
    check(lat == EXP_LAT, "R4 latency for zero", M'(lat), M'(EXP_LAT));
  endtask

  task automatic t_random();
    logic [M-1:0] a, r;
    int lat;
    for (int n = 0; n < 6; n++) begin
      a = rand_elem();
      if (a == '0) a = M'(3);
      if (n == 0) a = '1;
      run_op(a, r, lat);
      check(ref_mul(a, r) == M'(1), "R1 a times result is one", ref_mul(a, r), M'(1));
      check(lat == EXP_LAT, "R4 latency for random operand", M'(lat), M'(EXP_LAT));
    end
  endtask

  task automatic t_busy_flag();
    logic [M-1:0] a, r;
    int lat;
    bit all_busy;
    a = rand_elem() | M'(1);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    all_busy = 1'b1;
    lat = 0;
    while (!out_valid && lat < 400) begin
      if (!busy) all_busy = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check(all_busy, "R5 busy held until result", M'(all_busy), M'(1));
    check(!busy, "R5 busy low with result strobe", M'(busy), '0);
    r = out_data;
    check(ref_mul(a, r) == M'(1), "R1 result under busy watch", ref_mul(a, r), M'(1));
  endtask

  task automatic t_ignore();
    logic [M-1:0] a1, a2, r;
    int lat;
    bit extra;
    a1 = rand_elem() | M'(4);
    a2 = rand_elem() | M'(8);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin
      in_valid = (lat >= 10 && lat < 16);
      in_data  = a2;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    r = out_data;
    check(ref_mul(a1, r) == M'(1), "R6 operand kept while busy", ref_mul(a1, r), M'(1));
    check(lat == EXP_LAT, "R6 timing kept while busy", M'(lat), M'(EXP_LAT));
    extra = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (out_valid || busy) extra = 1'b1;
    end
    check(!extra, "R6 no run started by ignored operand", M'(extra), '0);
  endtask

  task automatic t_back_to_back();
    logic [M-1:0] a1, a2, r;
    int lat;
    a1 = rand_elem() | M'(16);
    a2 = rand_elem() | M'(32);
    run_op(a1, r, lat);
    check(ref_mul(a1, r) == M'(1), "R1 first of pair", ref_mul(a1, r), M'(1));
    in_valid = 1'b1;
    in_data  = a2;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(busy, "R9 operand taken during result cycle", M'(busy), M'(1));
    wait_result(r, lat);
    check(ref_mul(a2, r) == M'(1), "R9 second of pair", ref_mul(a2, r), M'(1));
    check(lat == EXP_LAT, "R9 latency of second", M'(lat), M'(EXP_LAT));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_zero();
    t_random();
    t_busy_flag();
    t_ignore();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule